// File: doc/BRIEF.md
# Hot Swap Fault Timer Sequencer

This block is the digital sequencer of a hot swap controller. It decides when the gate of the external pass FET may be driven, when the current-limit loop is active, and when the gate must be pulled down. Its inputs are comparator flags that are already synchronized: supply undervoltage, the board enable pin, sense voltage above the fault-timing level, sense voltage above the fast-trip level, and an external force-off request. An internal up/down counter takes the place of the timing capacitor. It climbs or falls at a step size chosen by the current phase. Those phases are the start-up delay, fault accumulation, cool-down after a trip, and discharge during normal running.

After power-up the enable input passes through a glitch filter, and its polarity is chosen by a parameter. A slow start-up ramp must reach the upper threshold before the gate is first enabled. Once the gate is on, a sense voltage above the fault-timing level starts a fast ramp. If that ramp reaches the upper threshold, the gate is cut. A sense voltage above the fast-trip level cuts the gate in the next cycle without any delay. A parameter selects what follows a trip. On a retry build, a slow cool-down runs to the lower threshold and start-up is then retried. On a latch-off build, the gate stays off until the enable is removed or the supply drops out.

Top module: `hs_seq_top`

## Requirements
- R1: After reset the state code is OFF (codes: 0 OFF, 1 INIT, 2 ON, 3 FAULT, 4 COOL, 5 LATCH). The gate enable, the regulate flag, the pull-down strobe and the timer value are all zero.
- R2: The raw enable pin is active-high when EN_ACT_HIGH=1 and active-low when EN_ACT_HIGH=0. A change of the pin is accepted only after FILT_CYC consecutive cycles at the new level, so shorter pulses have no effect. From an enabling pin change in OFF, INIT is entered FILT_CYC+1 cycles later.
- R3: Entering INIT clears the timer. The timer then rises by STEP_INIT per cycle. INIT lasts ceil(TH_HI/STEP_INIT) cycles, after which the state is ON, the gate enable is high and the timer reads TH_HI. The timer never exceeds TH_HI.
- R4: In ON the gate enable is high and the regulate flag is low. The timer falls by STEP_DN per cycle and stops at 0.
- R5: The fault-timing flag in ON moves the state to FAULT, where the regulate flag is high and the timer rises by STEP_FAULT per cycle. Starting from 0, FAULT lasts ceil(TH_HI/STEP_FAULT) cycles before the gate trips. If the flag clears first, the state returns to ON and the timer drains.
- R6: The fast-trip flag in ON or FAULT turns the gate enable off in the next cycle. In that same cycle the pull-down strobe is high for exactly one cycle and the timer reads TH_HI.
- R7: With AUTO_RETRY=1 a trip enters COOL. There the timer falls by STEP_COOL per cycle. After ceil((TH_HI-TH_LO)/STEP_COOL) cycles the state becomes OFF with the timer at TH_LO, and start-up is retried if the block is enabled. Removing the enable during COOL does not shorten it.
- R8: With AUTO_RETRY=0 a trip enters LATCH. The block stays there while the filtered enable is active and leaves to OFF only when the enable goes inactive or on undervoltage.
- R9: The force-off input moves INIT, ON or FAULT to OFF in the next cycle. OFF is held while force-off stays high.
- R10: Undervoltage moves any state to OFF with the timer cleared in the next cycle. OFF is held while undervoltage persists.
- R11: The filtered enable going inactive moves INIT, ON or FAULT to OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uvlo_i | input | 1 | Supply below lockout level |
| en_pin_i | input | 1 | Raw enable pin, polarity per EN_ACT_HIGH |
| oc_tim_i | input | 1 | Sense voltage above fault-timing level |
| oc_fast_i | input | 1 | Sense voltage above fast-trip level |
| force_off_i | input | 1 | External force-off (timer pin driven high) |
| gate_en_o | output | 1 | Gate drive enable |
| gate_reg_o | output | 1 | Current-limit regulation active |
| fast_pd_o | output | 1 | One-cycle fast gate pull-down strobe |
| state_o | output | 3 | Encoded sequencer state |
| timer_o | output | TIMER_W | Timer counter value |

## Verification
The bench counts the exact number of cycles spent in INIT, FAULT and COOL and compares each count with the ceiling division of threshold span by step size. An off-by-one in the saturating compare would lengthen or shorten the start-up or fault window by one cycle. It fires enable pulses one cycle shorter than the filter window, which a weak filter would pass and so start a ramp. It also drops the enable during cool-down, because a design that honoured it would go back to OFF early. A latch-off copy and an active-low copy run on the same stimulus. These expose a latch that re-arms while still enabled, a latch that misses the undervoltage clear, or an inverted polarity that starts a ramp with the board disabled. Fast trips are applied from both ON and FAULT to catch a missing or stretched pull-down strobe.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_INIT  = 3'd1,
    ST_ON    = 3'd2,
    ST_FAULT = 3'd3,
    ST_COOL  = 3'd4,
    ST_LATCH = 3'd5
  } seq_state_e;

  typedef enum logic [2:0] {
    TC_HOLD,
    TC_CLEAR,
    TC_TOP,
    TC_INIT_UP,
    TC_FAULT_UP,
    TC_COOL_DN,
    TC_DRAIN
  } tmr_cmd_e;
endpackage

// File: rtl/hs_en_filter.sv
module hs_en_filter #(
  parameter int FILT_CYC = 4,
  parameter bit ACT_HIGH = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic en_o
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYC - 1);

  logic          raw;
  logic [CW-1:0] cnt_q;
  logic          en_q;

  generate
    if (ACT_HIGH) begin : g_hi
      assign raw = pin_i;
    end else begin : g_lo
      assign raw = ~pin_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (raw == en_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q <= '0;
      en_q  <= raw;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/hs_ramp_timer.sv
module hs_ramp_timer
  import hs_seq_pkg::*;
#(
  parameter int TIMER_W    = 12,
  parameter int TH_HI      = 1300,
  parameter int TH_LO      = 200,
  parameter int STEP_INIT  = 5,
  parameter int STEP_FAULT = 60,
  parameter int STEP_COOL  = 3,
  parameter int STEP_DN    = 100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  tmr_cmd_e           cmd_i,
  output logic [TIMER_W-1:0] val_o,
  output logic               init_done_o,
  output logic               fault_done_o,
  output logic               cool_done_o
);
  localparam int SW = TIMER_W + 1;
  localparam logic [SW-1:0] HI_X    = SW'(TH_HI);
  localparam logic [SW-1:0] LO_X    = SW'(TH_LO);
  localparam logic [SW-1:0] INIT_X  = SW'(STEP_INIT);
  localparam logic [SW-1:0] FAULT_X = SW'(STEP_FAULT);
  localparam logic [SW-1:0] COOL_X  = SW'(STEP_COOL);
  localparam logic [SW-1:0] DN_X    = SW'(STEP_DN);

  logic [TIMER_W-1:0] val_q, val_d;
  logic [SW-1:0]      ext, up_init, up_fault;

  assign ext      = {1'b0, val_q};
  assign up_init  = ext + INIT_X;
  assign up_fault = ext + FAULT_X;

  assign init_done_o  = (up_init >= HI_X);
  assign fault_done_o = (up_fault >= HI_X);
  assign cool_done_o  = (ext <= LO_X + COOL_X);

  always_comb begin
    val_d = val_q;
    unique case (cmd_i)
      TC_CLEAR:    val_d = '0;
      TC_TOP:      val_d = TIMER_W'(TH_HI);
      TC_INIT_UP:  val_d = init_done_o  ? TIMER_W'(TH_HI) : up_init[TIMER_W-1:0];
      TC_FAULT_UP: val_d = fault_done_o ? TIMER_W'(TH_HI) : up_fault[TIMER_W-1:0];
      TC_COOL_DN:  val_d = cool_done_o  ? TIMER_W'(TH_LO) : val_q - TIMER_W'(STEP_COOL);
      TC_DRAIN:    val_d = (ext >= DN_X) ? val_q - TIMER_W'(STEP_DN) : '0;
      default:     val_d = val_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= val_d;
  end

  assign val_o = val_q;
endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
  import hs_seq_pkg::*;
#(
  parameter bit AUTO_RETRY = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       uvlo_i,
  input  logic       en_ok_i,
  input  logic       force_off_i,
  input  logic       oc_tim_i,
  input  logic       oc_fast_i,
  input  logic       init_done_i,
  input  logic       fault_done_i,
  input  logic       cool_done_i,
  output seq_state_e state_o,
  output tmr_cmd_e   cmd_o,
  output logic       fast_pd_o
);
  seq_state_e state_q, state_d, trip_st;
  logic       pd_q, pd_d;

  generate
    if (AUTO_RETRY) begin : g_retry
      assign trip_st = ST_COOL;
    end else begin : g_latch
      assign trip_st = ST_LATCH;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    cmd_o   = TC_DRAIN;
    pd_d    = 1'b0;
    if (uvlo_i) begin
      state_d = ST_OFF;
      cmd_o   = TC_CLEAR;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (en_ok_i && !force_off_i) begin
            state_d = ST_INIT;
            cmd_o   = TC_CLEAR;
          end
        end
        ST_INIT: begin
          if (force_off_i || !en_ok_i) begin
            state_d = ST_OFF;
          end else if (init_done_i) begin
            state_d = ST_ON;
            cmd_o   = TC_TOP;
          end else begin
            cmd_o   = TC_INIT_UP;
          end
        end
        ST_ON, ST_FAULT: begin
          if (oc_fast_i) begin
            state_d = trip_st;
            cmd_o   = TC_TOP;
            pd_d    = 1'b1;
          end else if (force_off_i || !en_ok_i) begin
            state_d = ST_OFF;
          end else if (state_q == ST_ON) begin
            if (oc_tim_i) state_d = ST_FAULT;
          end else if (!oc_tim_i) begin
            state_d = ST_ON;
          end else if (fault_done_i) begin
            state_d = trip_st;
            cmd_o   = TC_TOP;
          end else begin
            cmd_o   = TC_FAULT_UP;
          end
        end
        ST_COOL: begin
          cmd_o = TC_COOL_DN;
          if (cool_done_i) state_d = ST_OFF;
        end
        ST_LATCH: begin
          if (!en_ok_i) state_d = ST_OFF;
        end
        default: begin
          state_d = ST_OFF;
          cmd_o   = TC_CLEAR;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      pd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      pd_q    <= pd_d;
    end
  end

  assign state_o   = state_q;
  assign fast_pd_o = pd_q;
endmodule

// File: rtl/hs_seq_top.sv
module hs_seq_top
  import hs_seq_pkg::*;
#(
  parameter int TIMER_W     = 12,
  parameter int TH_HI       = 1300,
  parameter int TH_LO       = 200,
  parameter int STEP_INIT   = 5,
  parameter int STEP_FAULT  = 60,
  parameter int STEP_COOL   = 3,
  parameter int STEP_DN     = 100,
  parameter int FILT_CYC    = 4,
  parameter bit EN_ACT_HIGH = 1'b1,
  parameter bit AUTO_RETRY  = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               uvlo_i,
  input  logic               en_pin_i,
  input  logic               oc_tim_i,
  input  logic               oc_fast_i,
  input  logic               force_off_i,
  output logic               gate_en_o,
  output logic               gate_reg_o,
  output logic               fast_pd_o,
  output logic [2:0]         state_o,
  output logic [TIMER_W-1:0] timer_o
);
  logic       en_ok;
  logic       init_done, fault_done, cool_done;
  tmr_cmd_e   tcmd;
  seq_state_e st;

  hs_en_filter #(
    .FILT_CYC(FILT_CYC),
    .ACT_HIGH(EN_ACT_HIGH)
  ) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (en_pin_i),
    .en_o  (en_ok)
  );

  hs_ramp_timer #(
    .TIMER_W   (TIMER_W),
    .TH_HI     (TH_HI),
    .TH_LO     (TH_LO),
    .STEP_INIT (STEP_INIT),
    .STEP_FAULT(STEP_FAULT),
    .STEP_COOL (STEP_COOL),
    .STEP_DN   (STEP_DN)
  ) u_tmr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (tcmd),
    .val_o       (timer_o),
    .init_done_o (init_done),
    .fault_done_o(fault_done),
    .cool_done_o (cool_done)
  );

  hs_seq_fsm #(
    .AUTO_RETRY(AUTO_RETRY)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .uvlo_i      (uvlo_i),
    .en_ok_i     (en_ok),
    .force_off_i (force_off_i),
    .oc_tim_i    (oc_tim_i),
    .oc_fast_i   (oc_fast_i),
    .init_done_i (init_done),
    .fault_done_i(fault_done),
    .cool_done_i (cool_done),
    .state_o     (st),
    .cmd_o       (tcmd),
    .fast_pd_o   (fast_pd_o)
  );

  assign state_o    = st;
  assign gate_en_o  = (st == ST_ON) || (st == ST_FAULT);
  assign gate_reg_o = (st == ST_FAULT);
endmodule

// File: rtl/hs_seq_chk.sv
module hs_seq_chk #(
  parameter int TIMER_W   = 12,
  parameter int TH_HI     = 1300,
  parameter int STEP_COOL = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               uvlo_i,
  input logic               oc_fast_i,
  input logic               force_off_i,
  input logic               en_ok_i,
  input logic               gate_en_i,
  input logic               gate_reg_i,
  input logic               fast_pd_i,
  input logic [2:0]         state_i,
  input logic [TIMER_W-1:0] timer_i
);
  localparam logic [2:0] S_OFF   = 3'd0;
  localparam logic [2:0] S_COOL  = 3'd4;
  localparam logic [2:0] S_LATCH = 3'd5;

  AST_UVLO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> (state_i == S_OFF) && !gate_en_i && (timer_i == '0)); // R10

  AST_FAST_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_en_i && oc_fast_i && !uvlo_i) |=> !gate_en_i && fast_pd_i); // R6

  AST_STROBE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_pd_i |=> !fast_pd_i); // R6

  AST_TIMER_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_i <= TIMER_W'(TH_HI)); // R3

  AST_REG_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_reg_i |-> gate_en_i); // R5

  AST_FORCE_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_off_i && gate_en_i && !oc_fast_i) |=> (state_i == S_OFF)); // R9

  AST_COOL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_COOL && !uvlo_i) |=>
      (timer_i == $past(timer_i) - TIMER_W'(STEP_COOL)) || (state_i == S_OFF)); // R7

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_LATCH && en_ok_i && !uvlo_i) |=> (state_i == S_LATCH)); // R8
endmodule

bind hs_seq_top hs_seq_chk #(
  .TIMER_W  (TIMER_W),
  .TH_HI    (TH_HI),
  .STEP_COOL(STEP_COOL)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .uvlo_i     (uvlo_i),
  .oc_fast_i  (oc_fast_i),
  .force_off_i(force_off_i),
  .en_ok_i    (en_ok),
  .gate_en_i  (gate_en_o),
  .gate_reg_i (gate_reg_o),
  .fast_pd_i  (fast_pd_o),
  .state_i    (state_o),
  .timer_i    (timer_o)
);

// File: tb/tb_hs_seq_top.sv
module tb_hs_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int TW  = 12;
  localparam int HI  = 1300;
  localparam int LO  = 200;
  localparam int SI  = 5;
  localparam int SF  = 60;
  localparam int SC  = 3;
  localparam int SD  = 100;
  localparam int FC  = 4;
  localparam int N_INIT  = (HI + SI - 1) / SI;
  localparam int N_FAULT = (HI + SF - 1) / SF;
  localparam int N_COOL  = (HI - LO + SC - 1) / SC;
  localparam int OFF = 0, INIT = 1, ON = 2, FLT = 3, COOL = 4, LATCH = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvlo = 1'b0, en = 1'b0, oc_tim = 1'b0, oc_fast = 1'b0, force_off = 1'b0;

  logic          g_a, r_a, p_a, g_l, r_l, p_l, g_n, r_n, p_n;
  logic [2:0]    s_a, s_l, s_n;
  logic [TW-1:0] t_a, t_l, t_n;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_seq_top #(.TIMER_W(TW), .TH_HI(HI), .TH_LO(LO), .STEP_INIT(SI), .STEP_FAULT(SF),
    .STEP_COOL(SC), .STEP_DN(SD), .FILT_CYC(FC), .EN_ACT_HIGH(1'b1), .AUTO_RETRY(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .uvlo_i(uvlo), .en_pin_i(en), .oc_tim_i(oc_tim),
    .oc_fast_i(oc_fast), .force_off_i(force_off), .gate_en_o(g_a), .gate_reg_o(r_a),
    .fast_pd_o(p_a), .state_o(s_a), .timer_o(t_a));

  hs_seq_top #(.TIMER_W(TW), .TH_HI(HI), .TH_LO(LO), .STEP_INIT(SI), .STEP_FAULT(SF),
    .STEP_COOL(SC), .STEP_DN(SD), .FILT_CYC(FC), .EN_ACT_HIGH(1'b1), .AUTO_RETRY(1'b0)) dut_l (
    .clk_i(clk), .rst_ni(rst_n), .uvlo_i(uvlo), .en_pin_i(en), .oc_tim_i(oc_tim),
    .oc_fast_i(oc_fast), .force_off_i(force_off), .gate_en_o(g_l), .gate_reg_o(r_l),
    .fast_pd_o(p_l), .state_o(s_l), .timer_o(t_l));

  hs_seq_top #(.TIMER_W(TW), .TH_HI(HI), .TH_LO(LO), .STEP_INIT(SI), .STEP_FAULT(SF),
    .STEP_COOL(SC), .STEP_DN(SD), .FILT_CYC(FC), .EN_ACT_HIGH(1'b0), .AUTO_RETRY(1'b1)) dut_n (
    .clk_i(clk), .rst_ni(rst_n), .uvlo_i(uvlo), .en_pin_i(~en), .oc_tim_i(oc_tim),
    .oc_fast_i(oc_fast), .force_off_i(force_off), .gate_en_o(g_n), .gate_reg_o(r_n),
    .fast_pd_o(p_n), .state_o(s_n), .timer_o(t_n));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // negedges on which dut sits in state st, starting at the current one
  task automatic dwell(input int st, output int n);
    n = 0;
    while (int'(s_a) == st && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_init(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (int'(s_a) != INIT && n < 1000);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int n;
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 state", s_a, OFF);
    check("R1 gate", g_a, 0);
    check("R1 reg", r_a, 0);
    check("R1 strobe", p_a, 0);
    check("R1 timer", t_a, 0);

    // R2 short pulse ignored on both polarities
    en = 1'b1;
    cycles(FC - 1);
    en = 1'b0;
    cycles(10);
    check("R2 glitch hi", s_a, OFF);
    check("R2 glitch lo", s_n, OFF);

    // R2 latency, R3 start-up ramp
    en = 1'b1;
    wait_init(n);
    check("R2 latency", n, FC + 1);
    check("R3 init clear", t_a, 0);
    check("R2 polarity", s_n, INIT);
    @(negedge clk);
    check("R3 step", t_a, SI);
    dwell(INIT, n);
    check("R3 init length", n + 1, N_INIT);
    check("R3 on", s_a, ON);
    check("R3 gate", g_a, 1);
    check("R3 top", t_a, HI);
    check("R2 polarity on", s_n, ON);

    // R4 drain
    @(negedge clk);
    check("R4 drain", t_a, HI - SD);
    cycles(20);
    check("R4 floor", t_a, 0);
    check("R4 reg low", r_a, 0);

    // R5 timed fault to trip
    oc_tim = 1'b1;
    @(negedge clk);
    check("R5 fault", s_a, FLT);
    check("R5 reg", r_a, 1);
    dwell(FLT, n);
    oc_tim = 1'b0;
    check("R5 fault length", n, N_FAULT);
    check("R7 cool", s_a, COOL);
    check("R8 latch", s_l, LATCH);
    check("R5 gate off", g_a, 0);
    check("R8 gate off", g_l, 0);
    check("R5 timer top", t_a, HI);
    check("R5 no strobe", p_a, 0);

    // R7 cool-down
    @(negedge clk);
    check("R7 cool step", t_a, HI - SC);
    dwell(COOL, n);
    check("R7 cool length", n + 1, N_COOL);
    check("R7 end off", s_a, OFF);
    check("R7 end low", t_a, LO);
    check("R8 held", s_l, LATCH);
    @(negedge clk);
    check("R7 retry", s_a, INIT);
    dwell(INIT, n);
    check("R7 retry on", s_a, ON);
    check("R8 held enabled", s_l, LATCH);

    // R6 fast trip from ON
    cycles(20);
    oc_fast = 1'b1;
    @(negedge clk);
    oc_fast = 1'b0;
    check("R6 gate", g_a, 0);
    check("R6 strobe", p_a, 1);
    check("R6 state", s_a, COOL);
    check("R6 timer", t_a, HI);
    @(negedge clk);
    check("R6 strobe one", p_a, 0);

    // R8 release on enable removal, R7 cool ignores enable
    en = 1'b0;
    cycles(FC + 2);
    check("R8 release", s_l, OFF);
    check("R7 cool kept", s_a, COOL);
    cycles(N_COOL + 5);
    check("R7 done disabled", s_a, OFF);
    check("R2 off low pol", s_n, OFF);

    // R11 enable removal during INIT
    en = 1'b1;
    wait_init(n);
    cycles(10);
    en = 1'b0;
    cycles(FC + 2);
    check("R11 init off", s_a, OFF);
    en = 1'b1;
    wait_init(n);
    dwell(INIT, n);
    check("R11 back on", s_a, ON);
    cycles(20);

    // R5 fault recovery
    oc_tim = 1'b1;
    @(negedge clk);
    check("R5 entry timer", t_a, 0);
    cycles(5);
    check("R5 ramp", t_a, 5 * SF);
    oc_tim = 1'b0;
    @(negedge clk);
    check("R5 recover", s_a, ON);
    check("R5 recover drain", t_a, 5 * SF - SD);
    @(negedge clk);
    check("R4 drain fault", t_a, 5 * SF - 2 * SD);
    check("R4 reg clear", r_a, 0);

    // R9 force-off
    cycles(5);
    force_off = 1'b1;
    @(negedge clk);
    check("R9 off", s_a, OFF);
    check("R9 gate", g_a, 0);
    cycles(10);
    check("R9 hold", s_a, OFF);
    force_off = 1'b0;
    @(negedge clk);
    check("R9 restart", s_a, INIT);

    // R6 fast trip from FAULT, R10 undervoltage clears latch
    dwell(INIT, n);
    cycles(20);
    oc_tim = 1'b1;
    cycles(4);
    oc_fast = 1'b1;
    @(negedge clk);
    oc_fast = 1'b0;
    oc_tim = 1'b0;
    check("R6 from fault", s_a, COOL);
    check("R6 strobe fault", p_a, 1);
    check("R6 latch strobe", p_l, 1);
    check("R8 latch again", s_l, LATCH);
    @(negedge clk);
    uvlo = 1'b1;
    @(negedge clk);
    check("R10 off", s_a, OFF);
    check("R10 timer", t_a, 0);
    check("R10 latch off", s_l, OFF);
    check("R10 latch timer", t_l, 0);
    cycles(10);
    check("R10 hold", s_a, OFF);
    uvlo = 1'b0;
    @(negedge clk);
    check("R10 restart", s_a, INIT);
    check("R10 latch restart", s_l, INIT);
    summary();
  end
endmodule